// File: doc/BRIEF.md
# Single-Pin Serial Trace Encoder

This block takes trace bytes from one source over an 8-bit valid/ready stream and sends them off-chip on a single output pin. Software picks the line code through a small configuration port. It can choose asynchronous NRZ framing, where each byte is sent as a start bit, eight data bits and a stop bit, or Manchester coding, where every data bit carries a transition in the middle of its period. A programmable prescaler sets how many clocks each line unit lasts. In NRZ mode a unit is one bit. In Manchester mode a unit is one half-bit.

The block has a one-byte holding register in front of the shifter. The source can therefore hand over the next byte while the current one is still on the pin, and consecutive bytes leave with no idle gap between them. Only one source is carried, so no identifiers are added to the stream. Configuration is meant to be written while the pin is idle.

Top module: `trace_pin_top`

## Requirements
- R1: `in_ready` is high exactly when the holding register is empty. It is high after reset, and it goes low in the cycle after a byte is accepted (`in_valid` and `in_ready` both high at a rising edge). It stays low until that byte moves into the shifter.
- R2: When no byte is being sent, the pin sits at its idle level. The idle level is high in NRZ mode and low in Manchester mode.
- R3: In NRZ mode each byte is sent as ten bits: a low start bit, then data bits 0 through 7 (least significant first), then a high stop bit.
- R4: In NRZ mode every bit holds the pin steady for prescaler+1 clocks. This includes a prescaler of 0, which gives one clock per bit.
- R5: In Manchester mode data bits go out least significant first. A 1 is sent as high then low, and a 0 as low then high, which gives 16 half-bits per byte.
- R6: In Manchester mode every half-bit holds the pin steady for prescaler+1 clocks. This includes a prescaler of 0.
- R7: A byte that is accepted while another is being sent begins on the pin in the clock right after the last unit of the earlier byte ends, with no idle unit between them.
- R8: A byte accepted while the block is idle keeps the pin at idle for one clock. Its first unit then starts on the next rising edge and lasts from that edge onward.
- R9: A configuration write with `cfg_sel`=0 sets the line code from `cfg_wdata[0]` (0 = NRZ, 1 = Manchester). A write with `cfg_sel`=1 sets the prescaler. Both take effect in the next cycle. After reset the line code is NRZ and the prescaler is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stream port, the shifter and the pin |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Trace byte on `in_data` is valid |
| in_ready | output | 1 | Holding register can take a byte |
| in_data | input | 8 | Trace byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects the target: 0 = line code, 1 = prescaler |
| cfg_wdata | input | PRESC_W | Configuration write data |
| pin_out | output | 1 | Serial trace pin |

## Verification
Most internal faults show up on the pin within one line unit. If the unit counter is off by one, a frame ends a unit early or late, and the next byte's start bit or the idle level appears in the wrong clock. If the rate counter is wrong, a unit lasts the wrong number of clocks, and this can be seen from the first unit of a frame. Two faults are hidden until the stream is busy: a holding register that fails to fill, and a reload that fails to happen. Both are exposed on the port by offering a second byte during a frame. The bench then checks that `in_ready` drops one clock after acceptance, and that the second frame follows the first with no gap.

// File: rtl/trace_pin_pkg.sv
package trace_pin_pkg;

  typedef enum logic {
    LC_NRZ   = 1'b0,
    LC_MANCH = 1'b1
  } line_code_e;

endpackage

// File: rtl/trace_pin_cfg.sv
module trace_pin_cfg
  import trace_pin_pkg::*;
#(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [PRESC_W-1:0] wr_data,
  output line_code_e         code,
  output logic [PRESC_W-1:0] presc
);

  line_code_e         code_d;
  logic [PRESC_W-1:0] presc_d;

  always_comb begin
    code_d  = code;
    presc_d = presc;
    if (wr_en && !wr_sel) code_d  = line_code_e'(wr_data[0]);
    if (wr_en &&  wr_sel) presc_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= LC_NRZ;
      presc <= '0;
    end else begin
      code  <= code_d;
      presc <= presc_d;
    end
  end

endmodule

// File: rtl/trace_pin_hold.sv
module trace_pin_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              take,
  output logic              full,
  output logic [BYTE_W-1:0] data
);

  logic              full_d;
  logic              load_en;

  assign load_en = push && !full;

  always_comb begin
    full_d = full;
    if (take)    full_d = 1'b0;
    if (load_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (load_en) data <= push_data;
  end

endmodule

// File: rtl/trace_pin_rate.sv
module trace_pin_rate #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [PRESC_W-1:0] cnt;
  logic [PRESC_W-1:0] cnt_d;

  assign tick = run && (cnt == presc);

  always_comb begin
    if (run && !tick) cnt_d = cnt + 1'b1;
    else              cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/trace_pin_shift.sv
module trace_pin_shift
  import trace_pin_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_code_e        code,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [BYTE_W-1:0] hold_data,
  output logic              take,
  output logic              busy,
  output logic              pin
);

  localparam int UNIT_W    = $clog2(2 * BYTE_W + 2);
  localparam int NRZ_LAST  = BYTE_W + 1;
  localparam int MAN_LAST  = 2 * BYTE_W - 1;

  logic [UNIT_W-1:0] unit;
  logic [UNIT_W-1:0] unit_d;
  logic [UNIT_W-1:0] last_unit;
  logic [BYTE_W-1:0] data_q;
  logic              busy_d;
  logic              at_end;
  logic [BYTE_W-1:0] nrz_shift;
  logic [BYTE_W-1:0] man_shift;

  assign last_unit = (code == LC_MANCH) ? UNIT_W'(MAN_LAST) : UNIT_W'(NRZ_LAST);
  assign at_end    = busy && tick && (unit == last_unit);
  assign take      = hold_full && (!busy || at_end);

  always_comb begin
    busy_d = busy;
    unit_d = unit;
    if (take) begin
      busy_d = 1'b1;
      unit_d = '0;
    end else if (at_end) begin
      busy_d = 1'b0;
      unit_d = '0;
    end else if (busy && tick) begin
      unit_d = unit + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      unit <= '0;
    end else begin
      busy <= busy_d;
      unit <= unit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (take) data_q <= hold_data;
  end

  assign nrz_shift = data_q >> (unit - 1'b1);
  assign man_shift = data_q >> unit[UNIT_W-1:1];

  always_comb begin
    if (!busy) begin
      pin = (code == LC_NRZ);
    end else if (code == LC_MANCH) begin
      pin = man_shift[0] ^ unit[0];
    end else if (unit == '0) begin
      pin = 1'b0;
    end else if (unit == last_unit) begin
      pin = 1'b1;
    end else begin
      pin = nrz_shift[0];
    end
  end

endmodule

// File: rtl/trace_pin_top.sv
module trace_pin_top
  import trace_pin_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PRESC_W-1:0] cfg_wdata,
  output logic               pin_out
);

  logic               rst_meta;
  logic               rst_sync_n;
  line_code_e         code;
  logic [PRESC_W-1:0] presc;
  logic               hold_full;
  logic [BYTE_W-1:0]  hold_data;
  logic               take;
  logic               shift_busy;
  logic               unit_tick;
  logic               mode_manch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  trace_pin_cfg #(.PRESC_W(PRESC_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .code    (code),
    .presc   (presc)
  );

  trace_pin_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (in_valid),
    .push_data (in_data),
    .take      (take),
    .full      (hold_full),
    .data      (hold_data)
  );

  trace_pin_rate #(.PRESC_W(PRESC_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (shift_busy),
    .presc (presc),
    .tick  (unit_tick)
  );

  trace_pin_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .code      (code),
    .tick      (unit_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .busy      (shift_busy),
    .pin       (pin_out)
  );

  assign in_ready   = !hold_full;
  assign mode_manch = (code == LC_MANCH);

endmodule

// File: rtl/trace_pin_chk.sv
module trace_pin_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic pin_out,
  input logic busy,
  input logic tick,
  input logic mode_manch
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R1

  AST_IDLE_HIGH_NRZ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !mode_manch |-> pin_out); // R2

  AST_IDLE_LOW_MANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && mode_manch |-> !pin_out); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !mode_manch |-> !pin_out); // R3

  AST_UNIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(tick) |-> $stable(pin_out)); // R4

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_ready |=> busy); // R7

endmodule

bind trace_pin_top trace_pin_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pin_out    (pin_out),
  .busy       (shift_busy),
  .tick       (unit_tick),
  .mode_manch (mode_manch)
);

// File: tb/trace_pin_top_tb.sv
module trace_pin_top_tb;

  localparam int PW = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [7:0]    in_data;
  logic          cfg_we;
  logic          cfg_sel;
  logic [PW-1:0] cfg_wdata;
  logic          pin_out;

  int checks;
  int failures;
  bit done;

  trace_pin_top #(.PRESC_W(PW), .BYTE_W(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .pin_out   (pin_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit unit_val(input bit manch, input logic [7:0] d, input int u);
    if (manch) return d[u/2] ^ u[0];
    if (u == 0) return 1'b0;
    if (u == 9) return 1'b1;
    return d[u-1];
  endfunction

  task automatic cfg_write(input bit sel, input int val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = PW'(val);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Offer a byte to an idle block; returns just after the accepting edge's negedge.
  task automatic offer_idle(input logic [7:0] d, input bit manch);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1 ready after accept", in_ready, 0);
    check(pin_out == !manch, "R8 idle clock before first unit", pin_out, !manch);
  endtask

  // Checks a full frame negedge by negedge; optionally offers a second byte on the first unit.
  task automatic check_frame(input bit manch, input int p, input logic [7:0] d,
                             input bit inject, input logic [7:0] nxt);
    int units = manch ? 16 : 10;
    int k = 0;
    for (int u = 0; u < units; u++) begin
      bit bad = 0;
      bit seen = 0;
      for (int c = 0; c <= p; c++) begin
        @(negedge clk);
        if (pin_out !== unit_val(manch, d, u)) begin
          bad  = 1;
          seen = pin_out;
        end
        if (inject && k == 0) begin
          in_valid = 1'b1;
          in_data  = nxt;
        end
        if (inject && k == 1) begin
          in_valid = 1'b0;
          check(in_ready == 1'b0, "R1 ready low while byte held", in_ready, 0);
        end
        k++;
      end
      if (manch) check(!bad, "R5/R6 manchester half-bit", seen, unit_val(manch, d, u));
      else       check(!bad, "R3/R4 nrz bit", seen, unit_val(manch, d, u));
    end
  endtask

  task automatic check_idle_after(input bit manch);
    @(negedge clk);
    check(pin_out == !manch, "R2 idle level after frame", pin_out, !manch);
    check(in_ready == 1'b1, "R1 ready when empty", in_ready, 1);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    check(pin_out == 1'b1, "R2 R9 reset NRZ idle high", pin_out, 1);
  endtask

  task automatic t_nrz_single(input int p, input logic [7:0] d);
    cfg_write(1'b1, p);
    offer_idle(d, 1'b0);
    check_frame(1'b0, p, d, 1'b0, 8'h00);
    check_idle_after(1'b0);
  endtask

  task automatic t_manch_single(input int p, input logic [7:0] d);
    cfg_write(1'b0, 1);
    @(negedge clk);
    check(pin_out == 1'b0, "R2 R9 manchester idle low", pin_out, 0);
    cfg_write(1'b1, p);
    offer_idle(d, 1'b1);
    check_frame(1'b1, p, d, 1'b0, 8'h00);
    check_idle_after(1'b1);
  endtask

  task automatic t_pair(input bit manch, input int p, input logic [7:0] a, input logic [7:0] b);
    cfg_write(1'b0, manch);
    cfg_write(1'b1, p);
    offer_idle(a, manch);
    check_frame(manch, p, a, 1'b1, b);   // R7: b follows with no gap
    check_frame(manch, p, b, 1'b0, 8'h00);
    check_idle_after(manch);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    cfg_we   = 1'b0;
    cfg_sel  = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nrz_single(3, 8'hA5);
    t_nrz_single(0, 8'h3C);
    t_manch_single(1, 8'h96);
    t_pair(1'b1, 0, 8'hF0, 8'h0F);
    t_pair(1'b0, 2, 8'h81, 8'h7E);
    t_manch_single(2, 8'h01);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule